// File: doc/BRIEF.md
# External Bus Access Phase Sequencer

This block runs one access on an external memory-style bus as a fixed sequence of three phases: a setup (lead) phase, a strobe (active) phase and a hold (trail) phase. Each phase lasts a number of timing-clock cycles. That number comes from a timing word held for each of several address zones. The word carries separate phase counts for reads and for writes, a bit that doubles the programmed counts, and a bit that lets an external ready line stretch the strobe phase with wait states.

A client raises a request with a zone number, a direction and an address while the sequencer is idle. The sequencer then drives the chip-select for that zone through all three phases and the read or write strobe during the strobe phase. It pulses a completion flag once the hold phase has ended. Whatever counts are programmed are carried out as they stand: a zero count shortens or removes its phase and is never flagged as an error. The timing words come from outside the block as one flat input vector.

Top module: `bus_phase_seq`

## Requirements
- R1: Every access passes through setup, then strobe, then hold, never returning to an earlier phase; the chip-select bit of the requested zone (csOut bit = zone number) is high on every cycle of all three phases, and csOut is zero when idle.
- R2: Each zone owns a 16-bit slice of zoneTiming at bit offset zone*16, laid out as: bits [1:0] read setup, [4:2] read strobe, [6:5] read hold, [8:7] write setup, [11:9] write strobe, [13:12] write hold, bit 14 doubling, bit 15 ready-use. A read uses only the read fields, a write only the write fields.
- R3: With doubling off, setup lasts S cycles, strobe lasts A + W + 1 cycles and hold lasts H cycles, where W is the number of wait states.
- R4: With doubling on, setup lasts 2S cycles, strobe lasts 2A + W + 1 cycles and hold lasts 2H cycles; the wait-state count W is added once and is not doubled.
- R5: When the zone's ready-use bit is set, extReady is looked at only on the last programmed strobe cycle and each cycle after it; every cycle it is seen low adds one strobe cycle, and the strobe phase ends on the first cycle it is seen high. When the bit is clear, extReady has no effect and W is zero.
- R6: Zero counts are executed without any check: a zero setup count gives no setup cycle, and a zero hold count gives no hold cycle.
- R7: rdStrobe (reads) or wrStrobe (writes) is high exactly on the strobe-phase cycles; the two are never high together and neither is high outside the strobe phase.
- R8: done is high for exactly one cycle, the first cycle after the last cycle of the access.
- R9: A request is taken only while the sequencer is idle; a request raised during an access is dropped and does not start a later access.
- R10: The timing fields, direction, zone and address are captured when the access starts; changes to zoneTiming during an access do not alter it.
- R11: While reset is asserted and right after it, csOut, rdStrobe, wrStrobe and done are all low.
- R12: busAddr presents the requested address on every cycle of the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, taken only when idle |
| reqZone | input | ZONE_W (2) | Zone number of the request |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | ADDR_W (16) | Address of the request |
| zoneTiming | input | NUM_ZONES*16 (64) | Timing words of all zones, zone z at bits [z*16 +: 16] |
| extReady | input | 1 | External ready, used for wait states |
| csOut | output | NUM_ZONES (4) | Active-high chip-select, one bit per zone |
| rdStrobe | output | 1 | Read strobe, high during the strobe phase of reads |
| wrStrobe | output | 1 | Write strobe, high during the strobe phase of writes |
| busAddr | output | ADDR_W (16) | Address held for the access |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions guard the phase order (no step back from strobe to setup, and hold leads only to itself or idle). They also cover the one-hot chip-select, the exclusive strobes, that a low ready holds the strobe phase, that captured fields and address stay put during an access, and that the completion pulse never spans two cycles. The exact phase lengths under the normal and doubled formulas, the ready-driven stretch, the zero-count shortcuts, and the effect of a dropped request or a rewritten timing word during an access all depend on counts across a whole access. Only the bench's scenarios can show these, by measuring the lengths at the pins.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } phase_e;

  typedef struct packed {
    logic accept;      // capture request and load the first phase count
    logic loadActive;  // load the strobe-phase count
    logic loadTrail;   // load the hold-phase count
    logic decCnt;      // count down one cycle
  } ctrl_strobes_t;

endpackage

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int ADDR_W    = 16,
  parameter int LEAD_W    = 2,
  parameter int ACT_W     = 3,
  parameter int TRAIL_W   = 2,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int DIR_W    = LEAD_W + ACT_W + TRAIL_W,
  localparam int CFG_W    = 2 * DIR_W + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobes_t               strobes,
  input  phase_e                      phase,
  input  logic [ZONE_W-1:0]           reqZone,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [NUM_ZONES*CFG_W-1:0]  zoneTiming,
  output logic                        reqLeadZero,
  output logic                        cntZero,
  output logic                        trailZero,
  output logic                        useReady,
  output logic                        isWrite,
  output logic [ZONE_W-1:0]           zoneQ,
  output logic [ADDR_W-1:0]           addrQ
);

  // counter wide enough for 2*max(strobe count)
  localparam int CNT_W   = ACT_W + 2;
  localparam int RA_LO   = LEAD_W;
  localparam int RT_LO   = LEAD_W + ACT_W;
  localparam int WL_LO   = DIR_W;
  localparam int WA_LO   = DIR_W + LEAD_W;
  localparam int WT_LO   = DIR_W + LEAD_W + ACT_W;
  localparam int DBL_BIT = 2 * DIR_W;
  localparam int RDY_BIT = 2 * DIR_W + 1;

  logic [CFG_W-1:0]   cfgArr [NUM_ZONES];
  logic [CFG_W-1:0]   selCfg;
  logic [LEAD_W-1:0]  selLead;
  logic [ACT_W-1:0]   selAct;
  logic [TRAIL_W-1:0] selTrail;

  logic [ACT_W-1:0]   actQ;
  logic [TRAIL_W-1:0] trailQ;
  logic               dblQ;
  logic               useRdyQ;
  logic               isWriteQ;
  logic [CNT_W-1:0]   cnt;

  genvar g;
  generate
    for (g = 0; g < NUM_ZONES; g++) begin : gZoneCfg
      assign cfgArr[g] = zoneTiming[g*CFG_W +: CFG_W];
    end
  endgenerate

  function automatic logic [CNT_W-1:0] scaleCnt(input logic [CNT_W-1:0] v,
                                                 input logic dbl);
    return dbl ? (v << 1) : v;
  endfunction

  always_comb begin
    selCfg = cfgArr[reqZone];
    if (reqWrite) begin
      selLead  = selCfg[WL_LO +: LEAD_W];
      selAct   = selCfg[WA_LO +: ACT_W];
      selTrail = selCfg[WT_LO +: TRAIL_W];
    end else begin
      selLead  = selCfg[0 +: LEAD_W];
      selAct   = selCfg[RA_LO +: ACT_W];
      selTrail = selCfg[RT_LO +: TRAIL_W];
    end
  end

  assign reqLeadZero = (selLead == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ     <= '0;
      trailQ   <= '0;
      dblQ     <= 1'b0;
      useRdyQ  <= 1'b0;
      isWriteQ <= 1'b0;
      zoneQ    <= '0;
      addrQ    <= '0;
      cnt      <= '0;
    end else begin
      if (strobes.accept) begin
        actQ     <= selAct;
        trailQ   <= selTrail;
        dblQ     <= selCfg[DBL_BIT];
        useRdyQ  <= selCfg[RDY_BIT];
        isWriteQ <= reqWrite;
        zoneQ    <= reqZone;
        addrQ    <= reqAddr;
        if (selLead == '0)
          cnt <= scaleCnt(CNT_W'(selAct), selCfg[DBL_BIT]);
        else
          cnt <= scaleCnt(CNT_W'(selLead), selCfg[DBL_BIT]) - CNT_W'(1);
      end else if (strobes.loadActive) begin
        cnt <= scaleCnt(CNT_W'(actQ), dblQ);
      end else if (strobes.loadTrail) begin
        cnt <= scaleCnt(CNT_W'(trailQ), dblQ) - CNT_W'(1);
      end else if (strobes.decCnt) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign trailZero = (trailQ == '0);
  assign useReady  = useRdyQ;
  assign isWrite   = isWriteQ;

  // R10: captured fields do not move while an access runs
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> ($stable(actQ) && $stable(trailQ) && $stable(dblQ)
                            && $stable(useRdyQ) && $stable(isWriteQ)));

  // R12: address and zone stay fixed through the access
  a_r12_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> ($stable(addrQ) && $stable(zoneQ)));

endmodule

// File: rtl/bps_control.sv
module bps_control
  import bps_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqLeadZero,
  input  logic          cntZero,
  input  logic          trailZero,
  input  logic          useReady,
  input  logic          extReady,
  output ctrl_strobes_t strobes,
  output phase_e        phase,
  output logic          doneQ
);

  phase_e nextPhase;
  logic   finish;

  always_comb begin
    nextPhase = phase;
    strobes   = '0;
    finish    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          strobes.accept = 1'b1;
          nextPhase = reqLeadZero ? PH_ACTIVE : PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (cntZero) begin
          strobes.loadActive = 1'b1;
          nextPhase = PH_ACTIVE;
        end else begin
          strobes.decCnt = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (!cntZero) begin
          strobes.decCnt = 1'b1;
        end else if (!useReady || extReady) begin
          if (trailZero) begin
            finish    = 1'b1;
            nextPhase = PH_IDLE;
          end else begin
            strobes.loadTrail = 1'b1;
            nextPhase = PH_TRAIL;
          end
        end
      end
      PH_TRAIL: begin
        if (cntZero) begin
          finish    = 1'b1;
          nextPhase = PH_IDLE;
        end else begin
          strobes.decCnt = 1'b1;
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= nextPhase;
      doneQ <= finish;
    end
  end

  // R1: strobe phase never steps back to setup
  a_r1_no_return_lead: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE) |=> (phase != PH_LEAD));

  // R1: hold phase only continues or ends
  a_r1_trail_exit: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TRAIL) |=> (phase == PH_TRAIL || phase == PH_IDLE));

  // R5: a low ready after the programmed count keeps the strobe phase
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE && cntZero && useReady && !extReady) |=> (phase == PH_ACTIVE));

  // R8: completion pulse lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: an idle request always starts an access
  a_r9_idle_accept: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && reqValid) |=> (phase != PH_IDLE));

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bps_pkg::*;
#(
  parameter int NUM_ZONES = 4,
  parameter int ADDR_W    = 16,
  parameter int LEAD_W    = 2,
  parameter int ACT_W     = 3,
  parameter int TRAIL_W   = 2,
  localparam int ZONE_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int CFG_W    = 2 * (LEAD_W + ACT_W + TRAIL_W) + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [ZONE_W-1:0]          reqZone,
  input  logic                       reqWrite,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [NUM_ZONES*CFG_W-1:0] zoneTiming,
  input  logic                       extReady,
  output logic [NUM_ZONES-1:0]       csOut,
  output logic                       rdStrobe,
  output logic                       wrStrobe,
  output logic [ADDR_W-1:0]          busAddr,
  output logic                       done
);

  ctrl_strobes_t     strobes;
  phase_e            phase;
  logic              reqLeadZero;
  logic              cntZero;
  logic              trailZero;
  logic              useReady;
  logic              isWrite;
  logic [ZONE_W-1:0] zoneQ;
  logic              busy;

  bps_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLeadZero(reqLeadZero),
    .cntZero    (cntZero),
    .trailZero  (trailZero),
    .useReady   (useReady),
    .extReady   (extReady),
    .strobes    (strobes),
    .phase      (phase),
    .doneQ      (done)
  );

  bps_datapath #(
    .NUM_ZONES(NUM_ZONES),
    .ADDR_W   (ADDR_W),
    .LEAD_W   (LEAD_W),
    .ACT_W    (ACT_W),
    .TRAIL_W  (TRAIL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .phase      (phase),
    .reqZone    (reqZone),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .zoneTiming (zoneTiming),
    .reqLeadZero(reqLeadZero),
    .cntZero    (cntZero),
    .trailZero  (trailZero),
    .useReady   (useReady),
    .isWrite    (isWrite),
    .zoneQ      (zoneQ),
    .addrQ      (busAddr)
  );

  assign busy = (phase != PH_IDLE);

  genvar z;
  generate
    for (z = 0; z < NUM_ZONES; z++) begin : gCs
      assign csOut[z] = busy && (zoneQ == ZONE_W'(z));
    end
  endgenerate

  assign rdStrobe = (phase == PH_ACTIVE) && !isWrite;
  assign wrStrobe = (phase == PH_ACTIVE) && isWrite;

  // R1: at most one zone selected
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csOut));

  // R7: strobes exclusive and only inside a selected access
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  a_r7_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> (csOut != '0));

endmodule

// File: tb/sim_bus_phase_seq.sv
`timescale 1ns/1ps
module sim_bus_phase_seq;

  localparam int NZ = 4;
  localparam int AW = 16;
  localparam int CW = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0;
  logic [1:0]     reqZone = '0;
  logic           reqWrite = 1'b0;
  logic [AW-1:0]  reqAddr = '0;
  logic [NZ*CW-1:0] zoneTiming = '0;
  logic           extReady = 1'b0;
  logic [NZ-1:0]  csOut;
  logic           rdStrobe;
  logic           wrStrobe;
  logic [AW-1:0]  busAddr;
  logic           done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_phase_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZone(reqZone),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .zoneTiming(zoneTiming),
    .extReady(extReady), .csOut(csOut), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .busAddr(busAddr), .done(done)
  );

  typedef struct packed {
    logic [1:0] zone;
    logic       wr;
    logic [1:0] lead;
    logic [2:0] act;
    logic [1:0] trail;
    logic       dbl;
    logic       ur;
    logic [3:0] eLead;
    logic [4:0] eAct;
    logic [3:0] eTrail;
  } vec_t;

  // zone, wr, setup, strobe, hold, dbl, readyUse, expSetup, expStrobe, expHold
  localparam vec_t VECS [9] = '{
    '{2'd0, 1'b0, 2'd1, 3'd0, 2'd0, 1'b0, 1'b0, 4'd1, 5'd1,  4'd0}, // R3 minimum legal
    '{2'd1, 1'b1, 2'd2, 3'd3, 2'd1, 1'b0, 1'b0, 4'd2, 5'd4,  4'd1}, // R3 write
    '{2'd2, 1'b0, 2'd3, 3'd7, 2'd3, 1'b1, 1'b0, 4'd6, 5'd15, 4'd6}, // R4 all max doubled
    '{2'd3, 1'b1, 2'd1, 3'd2, 2'd2, 1'b1, 1'b1, 4'd2, 5'd8,  4'd4}, // R4/R5 3 waits, not doubled
    '{2'd0, 1'b1, 2'd3, 3'd0, 2'd0, 1'b0, 1'b1, 4'd3, 5'd3,  4'd0}, // R5 2 waits
    '{2'd1, 1'b0, 2'd2, 3'd1, 2'd1, 1'b0, 1'b1, 4'd2, 5'd2,  4'd1}, // R5 ready at once
    '{2'd2, 1'b1, 2'd1, 3'd5, 2'd0, 1'b1, 1'b0, 4'd2, 5'd11, 4'd0}, // R5 ready ignored
    '{2'd3, 1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 5'd1,  4'd0}, // R6 illegal all-zero
    '{2'd0, 1'b0, 2'd0, 3'd4, 2'd2, 1'b1, 1'b1, 4'd0, 5'd10, 4'd4}  // R6 zero setup, 1 wait
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // R2 layout; the unused direction gets other values (2,5,1)
  function automatic logic [CW-1:0] packCfg(input logic wr, input logic [1:0] l,
      input logic [2:0] a, input logic [1:0] t, input logic d, input logic u);
    logic [CW-1:0] c;
    c = '0;
    if (wr) begin
      c[1:0] = 2'd2; c[4:2] = 3'd5; c[6:5] = 2'd1;
      c[8:7] = l;    c[11:9] = a;   c[13:12] = t;
    end else begin
      c[1:0] = l;    c[4:2] = a;    c[6:5] = t;
      c[8:7] = 2'd2; c[11:9] = 3'd5; c[13:12] = 2'd1;
    end
    c[14] = d;
    c[15] = u;
    return c;
  endfunction

  // poke: 0 none, 1 request during access, 2 rewrite timing during access
  task automatic runAccess(input vec_t v, input logic [AW-1:0] addr,
                           input int poke, input string tag);
    int nLead = 0;
    int nAct = 0;
    int nTrail = 0;
    int cyc = 0;
    bit orderOk = 1'b1;
    bit csOk = 1'b1;
    bit addrOk = 1'b1;
    bit strobeOk = 1'b1;
    bit doneEarly = 1'b0;
    zoneTiming[v.zone*CW +: CW] = packCfg(v.wr, v.lead, v.act, v.trail, v.dbl, v.ur);
    @(negedge clk);
    reqValid = 1'b1; reqZone = v.zone; reqWrite = v.wr; reqAddr = addr;
    extReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 16'h0000;
    while (csOut != '0 && cyc < 100) begin
      cyc++;
      if (csOut != (4'b0001 << v.zone)) csOk = 1'b0;
      if (busAddr != addr) addrOk = 1'b0;
      if (done) doneEarly = 1'b1;
      if (rdStrobe || wrStrobe) begin
        if (rdStrobe != !v.wr || wrStrobe != v.wr) strobeOk = 1'b0;
        if (nTrail != 0) orderOk = 1'b0;
        nAct++;
      end else if (nAct == 0) begin
        nLead++;
      end else begin
        nTrail++;
      end
      extReady = v.ur && (rdStrobe || wrStrobe) && (nAct >= int'(v.eAct));
      if (poke == 1 && cyc == 2) begin
        reqValid = 1'b1; reqZone = v.zone + 2'd1; reqWrite = !v.wr; reqAddr = 16'hBEEF;
      end else if (poke == 1 && cyc == 3) begin
        reqValid = 1'b0;
      end
      if (poke == 2 && cyc == 1)
        zoneTiming[v.zone*CW +: CW] = packCfg(v.wr, 2'd3, 3'd7, 2'd3, !v.dbl, !v.ur);
      @(negedge clk);
    end
    extReady = 1'b0;
    check(v.eLead == 4'(nLead), tag, "setup cycles", nLead, int'(v.eLead));
    check(v.eAct == 5'(nAct), tag, "strobe cycles", nAct, int'(v.eAct));
    check(v.eTrail == 4'(nTrail), tag, "hold cycles", nTrail, int'(v.eTrail));
    check(orderOk && csOk, "R1", "order and chip-select", int'(orderOk && csOk), 1);
    check(strobeOk, "R7", "strobe direction", int'(strobeOk), 1);
    check(addrOk, "R12", "address held", int'(addrOk), 1);
    check(!doneEarly && done, "R8", "done after last cycle", int'(done), 1);
    @(negedge clk);
    check(!done, "R8", "done one cycle only", int'(done), 0);
    if (poke == 1)
      check(csOut == '0, "R9", "dropped request did not start", int'(csOut), 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 during reset
    check(csOut == '0 && !rdStrobe && !wrStrobe && !done, "R11",
          "outputs low in reset", int'({csOut, rdStrobe, wrStrobe, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(csOut == '0 && !rdStrobe && !wrStrobe && !done, "R11",
          "outputs low after reset", int'({csOut, rdStrobe, wrStrobe, done}), 0);

    for (int i = 0; i < 9; i++) begin
      string tag;
      tag = (i < 2) ? "R3" : (i < 4) ? "R4" : (i < 7) ? "R5" : "R6";
      runAccess(VECS[i], AW'(16'h1000 + i * 16'h0111), 0, tag);
    end

    // R9: request raised mid-access is dropped
    runAccess(VECS[1], 16'hA5A5, 1, "R9");
    // R10: timing word rewritten mid-access
    runAccess(VECS[3], 16'h5A5A, 2, "R10");
    // R2: same zone, other direction uses its own fields (2,5,1 -> 2,6,1)
    begin
      vec_t w;
      w = '{2'd2, 1'b0, 2'd2, 3'd5, 2'd1, 1'b0, 1'b0, 4'd2, 5'd6, 4'd1};
      zoneTiming[2*CW +: CW] = packCfg(1'b1, 2'd0, 3'd0, 2'd3, 1'b0, 1'b0);
      @(negedge clk);
      reqValid = 1'b1; reqZone = 2'd2; reqWrite = 1'b0; reqAddr = 16'h2222;
      @(negedge clk);
      reqValid = 1'b0;
      begin
        int n = 0;
        int s = 0;
        while (csOut != '0 && n < 100) begin
          n++;
          if (rdStrobe) s++;
          @(negedge clk);
        end
        check(n == 9, "R2", "read uses read fields, total cycles", n, 9);
        check(s == int'(w.eAct), "R2", "read strobe cycles", s, int'(w.eAct));
      end
      @(negedge clk);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule